// File: doc/BRIEF.md
# Staged Page Write Controller

This block sits between a byte-wide host command stream and a byte-addressed nonvolatile data array made of 32-byte pages. The host can never change the array directly. It first fills a 32-byte volatile staging buffer together with a target address. It then reads that buffer back to confirm that every byte arrived. Finally it issues a separate commit command that moves the whole buffer into the addressed page. A fourth command streams bytes out of the array.

Each 256-byte block of the array has a protection byte, kept in the array itself just above the data area. When that byte holds the lock code, commits into the block are refused. Commits are also refused when the target lies outside the data area or when the buffer holds nothing new since the last commit. The host sees each refusal as an error bit in the status byte that answers every commit.

The host side uses valid/ready handshakes in both directions. A flag marks command bytes. The array side is a single-port synchronous byte memory with one cycle of read latency.

Top module: `spad_write_ctrl`

## Requirements
- R1: After reset, out_valid and mem_en are low and in_ready is high. A buffer readback then reports target address 0000h and status byte 00h.
- R2: Command 0Fh (flagged) is followed by the target address, low byte first, and then data bytes. Each data byte is stored at buffer index addr[4:0], and the index rises by one per byte, wrapping from 31 to 0. The ending offset is the index of the last byte stored. The command clears the error and valid bits, and the first data byte sets valid.
- R3: Command AAh returns 35 bytes: target low, target high, status, then buffer indices 0 to 31. Status is bit7 error, bit6 valid, bit5 zero and bits4:0 ending offset. An offered output byte stays unchanged until it is taken.
- R4: Command 55h, when allowed, writes buffer index i to address {target[12:5], i} for all 32 indices. It then returns the status byte with both the error and valid bits clear.
- R5: A commit is refused when the target is 1FA0h or above. Nothing is written, and the reply has the error bit set.
- R6: A commit is refused when the protection byte at 1FA0h + target[12:8] reads 55h. Nothing is written, and the reply has the error bit set while the valid bit stays set.
- R7: A commit is refused when the buffer is not valid, for example a second commit without new data. Nothing is written, and the error bit is set.
- R8: Command F0h takes a 2-byte start address, low byte first, and streams bytes from consecutive addresses. Addresses 1FC0h and above return FFh without any array access.
- R9: A flagged byte that is not one of the four command codes is ignored. It and the unflagged bytes that follow it leave the buffer, target and status unchanged.
- R10: A flagged byte accepted while output is pending ends the current command and withdraws the pending output byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Host byte valid |
| in_ready | output | 1 | Controller accepts a host byte (low during a commit) |
| in_first | input | 1 | Host byte is a command code |
| in_data | input | 8 | Host byte |
| out_valid | output | 1 | Reply byte valid |
| out_ready | input | 1 | Host takes reply byte |
| out_data | output | 8 | Reply byte |
| mem_en | output | 1 | Array access enable |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 13 | Array byte address |
| mem_wdata | output | 8 | Array write data |
| mem_rdata | input | 8 | Array read data, valid one cycle after a read |

## Verification
A wrong buffer index or a wrong ending offset shows up in the next readback, both in the status byte and as data sitting at the wrong buffer positions. A valid or error flag that is held wrongly appears in the status reply of the very next commit. A wrong protection or range decision is invisible in that reply's timing, but it shows in the page contents the next time the page is streamed. The bench therefore follows every commit with a readback of the status and a full-page read-memory, and it checks the stream across the end of the protection area.

// File: rtl/spw_pkg.sv
package spw_pkg;
  localparam logic [7:0] CMD_LOAD   = 8'h0F;
  localparam logic [7:0] CMD_VERIFY = 8'hAA;
  localparam logic [7:0] CMD_COMMIT = 8'h55;
  localparam logic [7:0] CMD_FETCH  = 8'hF0;
  localparam logic [7:0] LOCK_CODE  = 8'h55;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LD_A0, ST_LD_A1, ST_LD_DATA, ST_VFY,
    ST_CM_CHK, ST_CM_PWAIT, ST_CM_XFER, ST_CM_REPLY,
    ST_FT_A0, ST_FT_A1, ST_FT
  } spw_state_e;
endpackage

// File: rtl/spw_scratchpad.sv
module spw_scratchpad #(
  parameter int DEPTH = 32,
  parameter int W     = 8,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [IW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [IW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] ram [DEPTH];

  // Single write port, registered read: maps to a block or distributed RAM.
  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
    rdata <= ram[raddr];
  end
endmodule

// File: rtl/spw_copy_guard.sv
module spw_copy_guard #(
  parameter int          AW       = 13,
  parameter int          BLKSH    = 8,
  parameter logic [15:0] DATA_END = 16'h1FA0,
  parameter logic [7:0]  LOCK     = 8'h55
) (
  input  logic [15:0]   tgt,
  input  logic          buf_valid,
  input  logic [7:0]    prot_byte,
  output logic          range_ok,
  output logic          locked,
  output logic [AW-1:0] prot_addr
);
  // Target must lie in the data area and the buffer must hold fresh data.
  assign range_ok  = buf_valid && (tgt < DATA_END);
  assign locked    = (prot_byte == LOCK);
  assign prot_addr = AW'(DATA_END) + AW'(tgt[AW-1:BLKSH]);
endmodule

// File: rtl/spad_write_ctrl.sv
module spad_write_ctrl
  import spw_pkg::*;
#(
  parameter int          AW          = 13,
  parameter int          PAGE_BYTES  = 32,
  parameter int          BLOCK_BYTES = 256,
  parameter logic [15:0] DATA_END    = 16'h1FA0,
  parameter logic [15:0] PROT_END    = 16'h1FC0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          in_first,
  input  logic [7:0]    in_data,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [7:0]    out_data,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic [7:0]    mem_rdata
);
  localparam int OFFW    = $clog2(PAGE_BYTES);
  localparam int BLKSH   = $clog2(BLOCK_BYTES);
  localparam int KW      = OFFW + 1;
  localparam int VFY_LEN = PAGE_BYTES + 3;

  spw_state_e      st_q;
  logic [15:0]     tgt_q, ptr_q;
  logic [OFFW-1:0] off_q, end_q, sp_raddr;
  logic [KW-1:0]   k_q;
  logic            sp_valid_q, cp_err_q, rd_pend_q;
  logic            out_valid_q;
  logic [7:0]      out_data_q, sp_rdata, status;
  logic            in_fire, out_fire, abort, sp_we;
  logic            range_ok, locked;
  logic [AW-1:0]   prot_addr;

  assign in_fire  = in_valid && in_ready;
  assign out_fire = out_valid_q && out_ready;
  assign abort    = in_fire && in_first;
  assign sp_we    = in_fire && !in_first && (st_q == ST_LD_DATA);
  assign status   = {cp_err_q, sp_valid_q, {(6-OFFW){1'b0}}, end_q};
  assign in_ready = !(st_q inside {ST_CM_CHK, ST_CM_PWAIT, ST_CM_XFER, ST_CM_REPLY});
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;
  assign sp_raddr  = (st_q == ST_VFY) ? OFFW'(k_q - KW'(3)) : k_q[OFFW-1:0];

  spw_scratchpad #(.DEPTH(PAGE_BYTES), .W(8)) u_buf (
    .clk(clk), .we(sp_we), .waddr(off_q), .wdata(in_data),
    .raddr(sp_raddr), .rdata(sp_rdata)
  );

  spw_copy_guard #(.AW(AW), .BLKSH(BLKSH), .DATA_END(DATA_END), .LOCK(LOCK_CODE)) u_guard (
    .tgt(tgt_q), .buf_valid(sp_valid_q), .prot_byte(mem_rdata),
    .range_ok(range_ok), .locked(locked), .prot_addr(prot_addr)
  );

  always_comb begin
    mem_en    = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = sp_rdata;
    case (st_q)
      ST_CM_CHK: if (range_ok) begin
        mem_en   = 1'b1;
        mem_addr = prot_addr;
      end
      ST_CM_XFER: if (rd_pend_q) begin
        mem_en   = 1'b1;
        mem_we   = 1'b1;
        mem_addr = {tgt_q[AW-1:OFFW], k_q[OFFW-1:0]};
      end
      ST_FT: if (!rd_pend_q && !out_valid_q && ptr_q < PROT_END) begin
        mem_en   = 1'b1;
        mem_addr = ptr_q[AW-1:0];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE;
      tgt_q <= '0; ptr_q <= '0; off_q <= '0; end_q <= '0; k_q <= '0;
      sp_valid_q <= 1'b0; cp_err_q <= 1'b0; rd_pend_q <= 1'b0;
      out_valid_q <= 1'b0; out_data_q <= '0;
    end else begin
      if (out_fire) out_valid_q <= 1'b0;
      if (abort) begin
        out_valid_q <= 1'b0;
        rd_pend_q   <= 1'b0;
        k_q         <= '0;
        case (in_data)
          CMD_LOAD: begin
            st_q <= ST_LD_A0; sp_valid_q <= 1'b0; cp_err_q <= 1'b0; end_q <= '0;
          end
          CMD_VERIFY: st_q <= ST_VFY;
          CMD_COMMIT: st_q <= ST_CM_CHK;
          CMD_FETCH:  st_q <= ST_FT_A0;
          default:    st_q <= ST_IDLE;
        endcase
      end else begin
        case (st_q)
          ST_LD_A0: if (in_fire) begin tgt_q[7:0] <= in_data; st_q <= ST_LD_A1; end
          ST_LD_A1: if (in_fire) begin
            tgt_q[15:8] <= in_data;
            off_q <= tgt_q[OFFW-1:0];
            st_q  <= ST_LD_DATA;
          end
          ST_LD_DATA: if (in_fire) begin
            end_q <= off_q; off_q <= off_q + OFFW'(1); sp_valid_q <= 1'b1;
          end
          ST_VFY: begin
            if (rd_pend_q) begin
              out_data_q <= sp_rdata; out_valid_q <= 1'b1; rd_pend_q <= 1'b0;
              k_q <= k_q + KW'(1);
              if (k_q == KW'(VFY_LEN - 1)) st_q <= ST_IDLE;
            end else if (!out_valid_q) begin
              if (k_q < KW'(3)) begin
                out_data_q  <= (k_q == '0) ? tgt_q[7:0] : (k_q == KW'(1)) ? tgt_q[15:8] : status;
                out_valid_q <= 1'b1;
                k_q <= k_q + KW'(1);
              end else rd_pend_q <= 1'b1;
            end
          end
          ST_CM_CHK: begin
            if (!range_ok) begin cp_err_q <= 1'b1; st_q <= ST_CM_REPLY; end
            else st_q <= ST_CM_PWAIT;
          end
          ST_CM_PWAIT: begin
            if (locked) begin cp_err_q <= 1'b1; st_q <= ST_CM_REPLY; end
            else begin st_q <= ST_CM_XFER; k_q <= '0; rd_pend_q <= 1'b0; end
          end
          ST_CM_XFER: begin
            if (!rd_pend_q) rd_pend_q <= 1'b1;
            else begin
              rd_pend_q <= 1'b0;
              k_q <= k_q + KW'(1);
              if (k_q == KW'(PAGE_BYTES - 1)) begin
                st_q <= ST_CM_REPLY; sp_valid_q <= 1'b0; cp_err_q <= 1'b0;
              end
            end
          end
          ST_CM_REPLY: if (!out_valid_q) begin
            out_data_q <= status; out_valid_q <= 1'b1; st_q <= ST_IDLE;
          end
          ST_FT_A0: if (in_fire) begin ptr_q[7:0] <= in_data; st_q <= ST_FT_A1; end
          ST_FT_A1: if (in_fire) begin ptr_q[15:8] <= in_data; st_q <= ST_FT; end
          ST_FT: begin
            if (rd_pend_q) begin
              out_data_q <= mem_rdata; out_valid_q <= 1'b1; rd_pend_q <= 1'b0;
              ptr_q <= ptr_q + 16'd1;
            end else if (!out_valid_q) begin
              if (ptr_q >= PROT_END) begin
                out_data_q <= 8'hFF; out_valid_q <= 1'b1; ptr_q <= ptr_q + 16'd1;
              end else rd_pend_q <= 1'b1;
            end
          end
          default: ;
        endcase
      end
    end
  end

  // Buffer load marks the staged data as valid.
  assert_load_sets_valid_R2: assert property (@(posedge clk) disable iff (rst)
    sp_we |=> sp_valid_q);
  // An offered reply byte is held until taken, unless a command withdraws it.
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid_q && !out_ready && !abort) |=> (out_valid_q && $stable(out_data_q)));
  // No array write ever lands in the protection area or beyond.
  assert_write_in_data_area_R5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr < AW'(DATA_END)));
  // A locked block read back during the check stops the transfer.
  assert_lock_blocks_write_R6: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_CM_PWAIT && locked) |=> !mem_we);
  // Array writes only happen while the staged buffer is valid.
  assert_write_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> sp_valid_q);
  // Streaming never touches the array at or above the end of the protection area.
  assert_fetch_range_R8: assert property (@(posedge clk) disable iff (rst)
    (st_q == ST_FT && mem_en) |-> (ptr_q < PROT_END));
  // A withdrawn reply byte is gone on the next cycle.
  assert_abort_clears_R10: assert property (@(posedge clk) disable iff (rst)
    abort |=> !out_valid_q);
endmodule

// File: tb/tb_spad_write_ctrl.sv
module tb_spad_write_ctrl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_first = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = '0;
  logic in_ready, out_valid, mem_en, mem_we;
  logic [7:0] out_data, mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [12:0] mem_addr;

  int checks = 0, fails = 0;

  logic [7:0] arr [int];
  logic [7:0] exp_mem [int];
  logic [7:0] sp_m [32];
  logic [15:0] tgt_m = '0;
  logic [4:0]  end_m = '0;
  logic        vld_m = 1'b0, err_m = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spad_write_ctrl dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .mem_en(mem_en),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata)
  );

  function automatic logic [7:0] arr_rd(int a);
    return arr.exists(a) ? arr[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] exp_rd(int a);
    return exp_mem.exists(a) ? exp_mem[a] : 8'hFF;
  endfunction
  function automatic logic [7:0] status_m();
    return {err_m, vld_m, 1'b0, end_m};
  endfunction

  // Array model: single port, one cycle read latency.
  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) arr[int'(mem_addr)] = mem_wdata;
      else mem_rdata <= arr_rd(int'(mem_addr));
    end
  end

  task automatic report_end();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete (actual hung, expected done)");
    report_end();
  end

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b, input logic f);
    in_valid = 1'b1; in_data = b; in_first = f;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    out_ready = 1'b1;
    while (!out_valid) @(negedge clk);
    b = out_data;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic do_load(input logic [15:0] a, input int n);
    logic [4:0] off;
    put(8'h0F, 1'b1); put(a[7:0], 1'b0); put(a[15:8], 1'b0);
    tgt_m = a; end_m = '0; vld_m = 1'b0; err_m = 1'b0; off = a[4:0];
    for (int i = 0; i < n; i++) begin
      logic [7:0] d;
      d = 8'($urandom);
      put(d, 1'b0);
      sp_m[off] = d; end_m = off; off = off + 5'd1; vld_m = 1'b1;
    end
  endtask

  task automatic do_verify(string req);
    logic [7:0] b;
    put(8'hAA, 1'b1);
    get(b); chk({req, " R3 addr lo"}, b, tgt_m[7:0]);
    get(b); chk({req, " R3 addr hi"}, b, tgt_m[15:8]);
    get(b); chk({req, " R3 status"}, b, status_m());
    for (int i = 0; i < 32; i++) begin
      get(b); chk({req, " R3 buffer byte"}, b, sp_m[i]);
    end
  endtask

  task automatic do_commit();
    logic [7:0] b;
    logic ok;
    string req;
    ok = 1'b1; req = "R4";
    if (!vld_m) begin ok = 1'b0; req = "R7"; end
    else if (tgt_m >= 16'h1FA0) begin ok = 1'b0; req = "R5"; end
    else if (exp_rd(32'h1FA0 + int'(tgt_m[12:8])) == 8'h55) begin ok = 1'b0; req = "R6"; end
    if (ok) begin
      for (int i = 0; i < 32; i++) exp_mem[int'({tgt_m[12:5], 5'(i)})] = sp_m[i];
      vld_m = 1'b0; err_m = 1'b0;
    end else err_m = 1'b1;
    put(8'h55, 1'b1);
    get(b); chk({req, " commit reply status"}, b, status_m());
  endtask

  task automatic do_fetch(input logic [15:0] a, input int n, string req);
    logic [7:0] b;
    put(8'hF0, 1'b1); put(a[7:0], 1'b0); put(a[15:8], 1'b0);
    for (int i = 0; i < n; i++) begin
      logic [15:0] x;
      x = a + 16'(i);
      get(b);
      chk({req, " R8 stream byte"}, b, (x >= 16'h1FC0) ? 8'hFF : exp_rd(int'(x)));
    end
  endtask

  initial begin
    logic [7:0] b;
    void'($urandom(32'd20250917));
    arr[32'h1FA3] = 8'h55; exp_mem[32'h1FA3] = 8'h55;
    arr[32'h1FAA] = 8'h55; exp_mem[32'h1FAA] = 8'h55;
    arr[32'h1FBE] = 8'h3C; exp_mem[32'h1FBE] = 8'h3C;
    arr[32'h1FBF] = 8'h5A; exp_mem[32'h1FBF] = 8'h5A;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("R1 out_valid", {7'd0, out_valid}, 8'd0);
    chk("R1 mem_en", {7'd0, mem_en}, 8'd0);
    chk("R1 in_ready", {7'd0, in_ready}, 8'd1);
    put(8'hAA, 1'b1);
    get(b); chk("R1 addr lo", b, 8'h00);
    get(b); chk("R1 addr hi", b, 8'h00);
    get(b); chk("R1 status", b, 8'h00);

    // R2/R4: full page at offset 0, verify, commit, read back
    do_load(16'h0120, 32);
    do_verify("R2 full page");
    do_commit();
    do_fetch(16'h0120, 32, "R4 page contents");
    // R7: second commit without new data
    do_commit();
    do_fetch(16'h0120, 32, "R7 page unchanged");

    // R2: wrap of the buffer index, partial load
    do_load(16'h0245, 32);
    do_verify("R2 wrap");
    do_load(16'h025C, 7);
    do_verify("R2 partial wrap");
    do_commit();
    do_fetch(16'h0240, 32, "R4 partial page");

    // R6: locked block 3
    do_load(16'h0340, 10);
    do_commit();
    do_verify("R6 valid kept");
    do_fetch(16'h0340, 32, "R6 page unchanged");

    // R5: target in protection area
    do_load(16'h1FA5, 4);
    do_commit();
    do_fetch(16'h1FA0, 32, "R5 protection area unchanged");

    // R8: stream across the end of the protection area
    do_fetch(16'h1FBE, 5, "R8 boundary");

    // R9: unknown command and stray bytes ignored
    do_load(16'h0400, 32);
    put(8'h77, 1'b1); put(8'h11, 1'b0); put(8'h22, 1'b0);
    do_verify("R9 unknown command");

    // R10: command byte withdraws a pending stream byte
    do_fetch(16'h0000, 2, "R10 prefix");
    repeat (3) @(negedge clk);
    chk("R10 output pending before abort", {7'd0, out_valid}, 8'd1);
    put(8'h0F, 1'b1);
    chk("R10 output withdrawn", {7'd0, out_valid}, 8'd0);
    tgt_m = '0; end_m = '0; vld_m = 1'b0; err_m = 1'b0;
    put(8'h00, 1'b0); put(8'h00, 1'b0);
    do_verify("R10 after abort");

    // Random rounds mixing locked blocks and out-of-range targets
    for (int r = 0; r < 40; r++) begin
      logic [15:0] a;
      int n;
      a = ($urandom % 8 == 0) ? 16'(16'h1FA0 + $urandom % 64) : 16'($urandom % 32'h1FA0);
      n = 1 + int'($urandom % 32);
      do_load(a, n);
      do_verify("R2 random");
      do_commit();
      if ($urandom % 4 == 0) do_commit();
      if (a < 16'h1FA0) do_fetch({a[15:5], 5'd0}, 32, "R4 random page");
    end

    report_end();
  end
endmodule